// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the device-side host interface of an embedded controller. A host reaches it through a small byte-wide I/O bus with three decoded offsets: a data port, a combined status/command port, and an interrupt control byte. The host paces every transfer itself by polling two handshake flags in the status byte. The input-full flag says a written byte is still waiting to be consumed. The output-full flag says a response byte is waiting in the data port.

Each byte the host writes is held in an input buffer. After a fixed latency it is consumed by a small sequencer. A byte written to the command offset starts a command: read, write, burst on, burst off or query. A read command takes one address byte and answers with the addressed register through the data port. A write command takes an address byte and then a data byte, and issues one write strobe on the internal register-space port. Query hands back the lowest pending event code. The block has no valid/ready back-pressure at either edge: the host is throttled only by the flags, and the register-space port must answer reads combinationally in the same cycle.

Top module: `ec_host_mailbox`

## Requirements
- R1: After reset the status byte, the data port and the interrupt control byte all read 0x00, and `sci_irq` is low.
- R2: A host write to offset 0x0 (data) or offset 0x4 (command) while the input-full flag (status bit 1) is clear is accepted. Bit 1 then reads 1 for exactly LAT_NORM cycles, counted from the cycle after the write; this becomes LAT_BURST cycles while burst mode is on. Status bit 3 reads 1 when the accepted byte was a command and 0 when it was data.
- R3: A host write to offset 0x0 or 0x4 while the input-full flag is set is dropped and has no effect on the transaction in progress.
- R4: Command 0x80 followed by an address byte loads the addressed register-space byte into the data port and sets the output-full flag (status bit 0). A host read of offset 0x0 returns that byte and clears bit 0.
- R5: Command 0x81 followed by an address byte and a data byte produces exactly one `reg_we` pulse carrying that address and data.
- R6: Command 0x82 sets the burst flag (status bit 4) and command 0x83 clears it.
- R7: A data byte that arrives with no read or write command in progress produces no `reg_we` pulse and no response, and leaves the sequencer idle.
- R8: Raising event line i marks event code i+1 pending and sets the pending-event flag (status bit 5). Command 0x84 returns the lowest pending code, or 0x00 if none is pending, and clears that event. Bit 5 clears once no event remains.
- R9: Offset 0x8 is a read/write interrupt control byte whose writes do not touch the input-full flag. `sci_irq` equals status bit 5 AND control bit 0.
- R10: A command byte accepted during an unfinished read or write sequence abandons that sequence and starts the new command.
- R11: A command byte other than 0x80 to 0x84 returns the sequencer to idle and changes no flag, register or response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 4 | Host byte offset: 0x0 data, 0x4 status/command, 0x8 interrupt control |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe, one cycle per byte |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, combinational from io_addr |
| reg_addr | output | 8 | Register-space address |
| reg_wdata | output | 8 | Register-space write byte |
| reg_we | output | 1 | Register-space write strobe |
| reg_rdata | input | 8 | Register-space read byte, combinational from reg_addr |
| evt_raise | input | NEVT | Event raise pulses, line i gives code i+1 |
| sci_irq | output | 1 | Event interrupt request to the host |

## Verification
The bench counts, cycle by cycle, how long the input-full flag stays high in both normal and burst mode. A design that consumed a byte one cycle early or late, or that ignored burst mode, would give the wrong count. It writes a second command while the flag is still set and checks that the first command still governs the transaction. A design that overwrote the held byte would turn that write into a read. It also sends stray data bytes, unknown commands and a command that arrives in the middle of a write sequence. A design that leaked a strobe or kept a stale sequencer state would leave a wrong byte in the register space. Queries are issued with several events pending and with none pending. This catches a wrong priority order, a pending-event flag that clears too soon, and a response other than 0x00 when nothing is pending.

// File: rtl/ec_mbox_pkg.sv
package ec_mbox_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RD_ADDR, SQ_WR_ADDR, SQ_WR_DATA} seq_state_t;

  localparam logic [7:0] CMD_READ      = 8'h80;
  localparam logic [7:0] CMD_WRITE     = 8'h81;
  localparam logic [7:0] CMD_BURST_ON  = 8'h82;
  localparam logic [7:0] CMD_BURST_OFF = 8'h83;
  localparam logic [7:0] CMD_QUERY     = 8'h84;

  localparam logic [3:0] PORT_DATA = 4'h0;
  localparam logic [3:0] PORT_CSR  = 4'h4;
  localparam logic [3:0] PORT_ICR  = 4'h8;
endpackage

// File: rtl/ec_mbox_inbuf.sv
module ec_mbox_inbuf #(
  parameter int LAT_NORM  = 4,
  parameter int LAT_BURST = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_data,
  input  logic       wr_cmd,
  input  logic [7:0] wdata,
  input  logic       burst,
  output logic       ibf,
  output logic       is_cmd,
  output logic [7:0] byte_q,
  output logic       take
);
  localparam int LMAX = (LAT_NORM > LAT_BURST) ? LAT_NORM : LAT_BURST;
  localparam int CW   = (LMAX < 2) ? 1 : $clog2(LMAX);
  localparam logic [CW-1:0] NORM_M1  = CW'(LAT_NORM - 1);
  localparam logic [CW-1:0] BURST_M1 = CW'(LAT_BURST - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lat_m1;
  logic          accept;

  assign accept = (wr_data | wr_cmd) & ~ibf;
  assign lat_m1 = burst ? BURST_M1 : NORM_M1;
  assign take   = ibf && (cnt == lat_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf    <= 1'b0;
      is_cmd <= 1'b0;
      byte_q <= '0;
      cnt    <= '0;
    end else if (accept) begin
      ibf    <= 1'b1;
      is_cmd <= wr_cmd;
      byte_q <= wdata;
      cnt    <= '0;
    end else if (take) begin
      ibf <= 1'b0;
    end else if (ibf) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && (wr_data || wr_cmd)) |=> ($stable(byte_q) && $stable(is_cmd)));

  // R2
  ibf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ibf);

  // R2
  ibf_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> (cnt == '0));
endmodule

// File: rtl/ec_mbox_events.sv
module ec_mbox_events #(
  parameter int NEVT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_raise,
  input  logic            query,
  output logic [7:0]      code,
  output logic            sci
);
  localparam int IW = (NEVT < 2) ? 1 : $clog2(NEVT);

  logic [NEVT-1:0] pend;
  logic [NEVT-1:0] clr_mask;
  logic [IW-1:0]   idx;
  logic            hit;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NEVT - 1; i >= 0; i--) begin
      if (pend[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
    clr_mask = hit ? (NEVT'(1) << idx) : '0;
    code     = hit ? (8'(idx) + 8'd1) : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      sci  <= 1'b0;
    end else begin
      pend <= (query ? (pend & ~clr_mask) : pend) | evt_raise;
      if (|evt_raise)
        sci <= 1'b1;
      else if (query && ((pend & ~clr_mask) == '0))
        sci <= 1'b0;
    end
  end

  // R8
  pend_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |-> sci);

  // R8
  query_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (query && hit && !(|evt_raise)) |=> !pend[$past(idx)]);
endmodule

// File: rtl/ec_mbox_seq.sv
module ec_mbox_seq
  import ec_mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       is_cmd,
  input  logic [7:0] byte_q,
  input  logic [7:0] reg_rdata,
  input  logic [7:0] evt_code,
  input  logic       host_rd_data,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic [7:0] obuf,
  output logic       obf,
  output logic       burst,
  output logic       query
);
  seq_state_t state;
  logic [7:0] addr_q;
  logic       rd_fire;
  logic       load;

  assign query     = take && is_cmd && (byte_q == CMD_QUERY);
  assign rd_fire   = take && !is_cmd && (state == SQ_RD_ADDR);
  assign reg_we    = take && !is_cmd && (state == SQ_WR_DATA);
  assign reg_addr  = rd_fire ? byte_q : addr_q;
  assign reg_wdata = byte_q;
  assign load      = query || rd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      addr_q <= '0;
      obuf   <= '0;
      obf    <= 1'b0;
      burst  <= 1'b0;
    end else begin
      if (load)
        obf <= 1'b1;
      else if (host_rd_data)
        obf <= 1'b0;
      if (query)   obuf <= evt_code;
      if (rd_fire) obuf <= reg_rdata;
      if (take) begin
        if (is_cmd) begin
          case (byte_q)
            CMD_READ:      state <= SQ_RD_ADDR;
            CMD_WRITE:     state <= SQ_WR_ADDR;
            CMD_BURST_ON:  begin burst <= 1'b1; state <= SQ_IDLE; end
            CMD_BURST_OFF: begin burst <= 1'b0; state <= SQ_IDLE; end
            default:       state <= SQ_IDLE;
          endcase
        end else begin
          case (state)
            SQ_WR_ADDR: begin addr_q <= byte_q; state <= SQ_WR_DATA; end
            default:    state <= SQ_IDLE;
          endcase
        end
      end
    end
  end

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (state == SQ_IDLE && !reg_we));

  // R4
  obf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf) |-> $past(take));

  // R7
  stray_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_cmd && state == SQ_IDLE && !host_rd_data)
      |=> ($stable(obf) && $stable(obuf) && state == SQ_IDLE));
endmodule

// File: rtl/ec_host_mailbox.sv
module ec_host_mailbox
  import ec_mbox_pkg::*;
#(
  parameter int LAT_NORM  = 4,
  parameter int LAT_BURST = 1,
  parameter int NEVT      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      io_addr,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  output logic [7:0]      reg_addr,
  output logic [7:0]      reg_wdata,
  output logic            reg_we,
  input  logic [7:0]      reg_rdata,
  input  logic [NEVT-1:0] evt_raise,
  output logic            sci_irq
);
  logic       wr_data, wr_cmd, host_rd_data;
  logic       ibf, is_cmd, take, burst, obf, query, sci;
  logic [7:0] byte_q, obuf, evt_code, icr, status;

  assign wr_data      = io_wr && (io_addr == PORT_DATA);
  assign wr_cmd       = io_wr && (io_addr == PORT_CSR);
  assign host_rd_data = io_rd && (io_addr == PORT_DATA);

  ec_mbox_inbuf #(.LAT_NORM(LAT_NORM), .LAT_BURST(LAT_BURST)) u_inbuf (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_cmd(wr_cmd),
    .wdata(io_wdata), .burst(burst), .ibf(ibf), .is_cmd(is_cmd),
    .byte_q(byte_q), .take(take)
  );

  ec_mbox_seq u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .is_cmd(is_cmd), .byte_q(byte_q),
    .reg_rdata(reg_rdata), .evt_code(evt_code), .host_rd_data(host_rd_data),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .obuf(obuf), .obf(obf), .burst(burst), .query(query)
  );

  ec_mbox_events #(.NEVT(NEVT)) u_events (
    .clk(clk), .rst_n(rst_n), .evt_raise(evt_raise), .query(query),
    .code(evt_code), .sci(sci)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      icr <= '0;
    else if (io_wr && io_addr == PORT_ICR)
      icr <= io_wdata;
  end

  assign status  = {2'b00, sci, burst, is_cmd, 1'b0, ibf, obf};
  assign sci_irq = sci & icr[0];

  always_comb begin
    case (io_addr)
      PORT_DATA: io_rdata = obuf;
      PORT_CSR:  io_rdata = status;
      PORT_ICR:  io_rdata = icr;
      default:   io_rdata = 8'h00;
    endcase
  end

  // R9
  icr_no_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_ICR && !ibf) |=> !ibf);
endmodule

// File: tb/tb_ec_host_mailbox.sv
module tb_ec_host_mailbox;
  localparam int LATN = 4;
  localparam int LATB = 1;
  localparam int NE   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    io_addr = '0;
  logic          io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]    io_wdata = '0;
  logic [7:0]    io_rdata, reg_addr, reg_wdata, reg_rdata;
  logic          reg_we, sci_irq;
  logic [NE-1:0] evt_raise = '0;

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int we_cnt = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ec_host_mailbox #(.LAT_NORM(LATN), .LAT_BURST(LATB), .NEVT(NE)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .evt_raise(evt_raise), .sci_irq(sci_irq)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_cnt = we_cnt + 1;
  end

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1; #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic wait_ibf();
    logic [7:0] s;
    int g = 0;
    do begin host_rd(4'h4, s); g++; end while (s[1] && g < 100);
  endtask

  task automatic wait_obf();
    logic [7:0] s;
    int g = 0;
    do begin host_rd(4'h4, s); g++; end while (!s[0] && g < 100);
  endtask

  task automatic meas_ibf(output int n, output logic cmdbit);
    io_addr = 4'h4; #1;
    cmdbit = io_rdata[3];
    n = 0;
    while (io_rdata[1] && n < 50) begin n++; @(negedge clk); #1; end
  endtask

  task automatic ec_rd(input logic [7:0] a, output logic [7:0] d);
    wait_ibf(); host_wr(4'h4, 8'h80);
    wait_ibf(); host_wr(4'h0, a);
    wait_obf(); host_rd(4'h0, d);
  endtask

  task automatic ec_wr(input logic [7:0] a, input logic [7:0] d);
    wait_ibf(); host_wr(4'h4, 8'h81);
    wait_ibf(); host_wr(4'h0, a);
    wait_ibf(); host_wr(4'h0, d);
    wait_ibf();
    expm[a] = d;
  endtask

  task automatic ec_query(output logic [7:0] d);
    wait_ibf(); host_wr(4'h4, 8'h84);
    wait_obf(); host_rd(4'h0, d);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, s;
    int n, w0;
    logic cb;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin mem[i] = init_val(i); expm[i] = init_val(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    host_rd(4'h4, v); chk("R1 status", v, 0);
    host_rd(4'h0, v); chk("R1 data", v, 0);
    host_rd(4'h8, v); chk("R1 icr", v, 0);
    chk("R1 sci_irq", sci_irq, 0);

    // R2 / R7 stray data byte: latency, cmd bit 0, no strobe, no response
    w0 = we_cnt;
    host_wr(4'h0, 8'h3C); meas_ibf(n, cb);
    chk("R2 ibf cycles normal", n, LATN);
    chk("R2 cmd bit data", cb, 0);
    wait_ibf(); host_rd(4'h4, s);
    chk("R7 no obf", s[0], 0);
    chk("R7 no strobe", we_cnt - w0, 0);

    // R11 unknown command: cmd bit 1, nothing changes
    host_wr(4'h4, 8'h55); meas_ibf(n, cb);
    chk("R2 ibf cycles cmd", n, LATN);
    chk("R2 cmd bit cmd", cb, 1);
    host_wr(4'h0, 8'h11); wait_ibf(); host_rd(4'h4, s);
    chk("R11 status after unknown", s & 8'hF7, 0);
    chk("R11 no strobe", we_cnt - w0, 0);

    // R3 overrun: second command dropped, write sequence proceeds
    host_wr(4'h4, 8'h81); host_wr(4'h4, 8'h80);
    wait_ibf(); host_wr(4'h0, 8'h20);
    wait_ibf(); host_wr(4'h0, 8'h5A);
    wait_ibf(); expm[8'h20] = 8'h5A;
    chk("R3 overrun write landed", mem[8'h20], 8'h5A);
    host_rd(4'h4, s); chk("R3 no read response", s[0], 0);

    // R4 read and OBF clear
    ec_rd(8'h20, v); chk("R4 read back", v, 8'h5A);
    host_rd(4'h4, s); chk("R4 obf cleared", s[0], 0);

    // R5 single strobe per write
    w0 = we_cnt; ec_wr(8'h41, 8'hC3);
    chk("R5 one strobe", we_cnt - w0, 1);
    chk("R5 data at addr", mem[8'h41], 8'hC3);

    // R4 R5 random mix
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a, d;
      a = 8'($urandom); d = 8'($urandom);
      if ($urandom % 2) ec_wr(a, d);
      else begin ec_rd(a, v); chk("R4 random read", v, expm[a]); end
    end

    // R10 command mid-sequence abandons write
    w0 = we_cnt;
    wait_ibf(); host_wr(4'h4, 8'h81);
    wait_ibf(); host_wr(4'h0, 8'h30);
    wait_ibf(); host_wr(4'h4, 8'h80);
    wait_ibf(); host_wr(4'h0, 8'h31);
    wait_obf(); host_rd(4'h0, v);
    chk("R10 read after abort", v, expm[8'h31]);
    chk("R10 no strobe", we_cnt - w0, 0);
    chk("R10 addr 0x30 intact", mem[8'h30], expm[8'h30]);

    // R6 burst on/off and latency
    wait_ibf(); host_wr(4'h4, 8'h82); wait_ibf();
    host_rd(4'h4, s); chk("R6 burst flag on", s[4], 1);
    host_wr(4'h0, 8'h00); meas_ibf(n, cb);
    chk("R2 ibf cycles burst", n, LATB);
    ec_wr(8'h77, 8'h19); ec_rd(8'h77, v); chk("R6 burst read", v, 8'h19);
    wait_ibf(); host_wr(4'h4, 8'h83); wait_ibf();
    host_rd(4'h4, s); chk("R6 burst flag off", s[4], 0);
    host_wr(4'h0, 8'h00); meas_ibf(n, cb);
    chk("R6 latency restored", n, LATN);
    wait_ibf();

    // R8 query with none pending
    ec_query(v); chk("R8 empty query", v, 0);
    host_rd(4'h4, s); chk("R8 sci clear", s[5], 0);

    // R8 / R9 events 2 and 5 pending
    @(negedge clk); evt_raise = 8'b0010_0100;
    @(negedge clk); evt_raise = '0;
    host_rd(4'h4, s); chk("R8 sci set", s[5], 1);
    chk("R9 irq masked", sci_irq, 0);
    host_wr(4'h8, 8'h01);
    host_rd(4'h4, s); chk("R9 icr write no ibf", s[1], 0);
    chk("R9 irq enabled", sci_irq, 1);
    ec_query(v); chk("R8 lowest code", v, 3);
    host_rd(4'h4, s); chk("R8 sci stays", s[5], 1);
    ec_query(v); chk("R8 next code", v, 6);
    host_rd(4'h4, s); chk("R8 sci cleared", s[5], 0);
    chk("R9 irq dropped", sci_irq, 0);
    ec_query(v); chk("R8 drained", v, 0);

    // R9 readback
    host_wr(4'h8, 8'hA5); host_rd(4'h8, v); chk("R9 icr readback", v, 8'hA5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule